// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Byte Memory Slave

This block is a byte-wide memory that answers a microcontroller bus on which the low address byte and the data byte share the same eight wires. The bus master places a 15-bit address with the low byte on the shared lines and the upper seven bits on dedicated lines. It then drops the address strobe, and the block latches the whole address. A read/write select level chooses the operation. A separate data strobe (E) times the data phase. On a read, the addressed byte is driven back once E goes high. On a write, the byte on the shared lines is stored when E falls.

All bus inputs are brought into the block's system clock domain through synchronisers. Edge detectors turn the strobes into single-cycle events. The shared-bus driver is modelled as a data output plus an output-enable, and the pad driver sits outside the block. The output-enable is asserted only during the read data phase, so the address phase and write phase never contend with the master. The storage holds 2^STORE_AW bytes, and STORE_AW = 15 gives the full 32K-byte array. The default of 11 keeps elaboration small, and the latched address bits above STORE_AW then alias.

Top module: `mux_bus_mem`

## Requirements
- R1: After reset `ad_oe` is 0, `ad_out` is 0 and the latched address is 0, so a data phase with no preceding address strobe accesses location 0.
- R2: A falling `bus_as` while `bus_ce` is 1 latches the address, with bits 7:0 taken from `ad_in` and bits 14:8 taken from `hi_addr`.
- R3: With `bus_rw` = 1 and `bus_ce` = 1, a rise of `bus_e` makes `ad_oe` 1 and `ad_out` equal to the byte at the latched address. Both appear on the third rising clock edge after `bus_e` rises, and not on the second.
- R4: With `bus_rw` = 0 and `bus_ce` = 1, the byte on `ad_in` is stored at the latched address when `bus_e` falls, and `ad_oe` stays 0 for the whole write cycle.
- R5: While `bus_ce` is 0 the block ignores the bus. An address strobe latches nothing, a falling E stores nothing, and `ad_oe` stays 0.
- R6: `ad_oe` returns to 0 on the third rising clock edge after `bus_e`, `bus_ce` or `bus_rw` goes low.
- R7: The latched address changes only on an enabled address-strobe fall, so repeated data phases without a new strobe reuse the last address.
- R8: Only the low STORE_AW bits of the latched address select a byte (default 11, so 2048 bytes), and addresses that differ only above that bit reach the same byte.
- R9: While `ad_oe` stays 1, `ad_out` holds its value even if `ad_in` or `hi_addr` change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_as | input | 1 | Address strobe; its falling edge latches the address |
| bus_e | input | 1 | Data strobe; rise starts read drive, fall stores write data |
| bus_rw | input | 1 | 1 selects read, 0 selects write |
| bus_ce | input | 1 | Active-high chip enable |
| hi_addr | input | 7 | Dedicated address bits 14:8 |
| ad_in | input | 8 | Shared bus as seen by the block: low address byte, then write data |
| ad_out | output | 8 | Read data for the shared bus |
| ad_oe | output | 1 | Drive enable for the shared bus; 0 means high impedance |

## Verification
Every input passes two synchroniser flops and one state register, so each result lands on the third rising edge after the pin change. This covers `ad_oe` rising after E rises and falling after E, CE or R/W drops. The bench drives pins on falling clock edges and samples three falling edges later. For R3 it also samples one edge earlier to show the output has not yet moved. Stored bytes and latched addresses are not visible right away. The bench checks them through a later read cycle, and it keeps address and data on the bus for four cycles after each strobe edge so the synchronised copies line up with the strobe.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
    localparam int MBM_DATA_W   = 8;
    localparam int MBM_HI_W     = 7;
    localparam int MBM_STORE_AW = 11;
    localparam int MBM_SYNC_N   = 2;

    // positions of the strobe bits inside the synchronised control vector
    localparam int CTL_AS = 0;
    localparam int CTL_E  = 1;
    localparam int CTL_RW = 2;
    localparam int CTL_CE = 3;
    localparam int CTL_W  = 4;
endpackage

// File: rtl/mbm_sync.sv
module mbm_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/mbm_edge.sv
module mbm_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign rise_o[b] =  lvl_i[b] & ~prev_q[b];
        assign fall_o[b] = ~lvl_i[b] &  prev_q[b];
    end
endmodule

// File: rtl/mbm_array.sv
module mbm_array #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_addr] <= wr_data;
        rd_data <= cells[rd_addr];
    end
endmodule

// File: rtl/mux_bus_mem.sv
module mux_bus_mem
    import mbm_pkg::*;
#(
    parameter int DATA_W   = MBM_DATA_W,
    parameter int HI_W     = MBM_HI_W,
    parameter int STORE_AW = MBM_STORE_AW,
    parameter int SYNC_N   = MBM_SYNC_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_as,
    input  logic              bus_e,
    input  logic              bus_rw,
    input  logic              bus_ce,
    input  logic [HI_W-1:0]   hi_addr,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe
);
    localparam int ADDR_W = DATA_W + HI_W;
    localparam int SYNC_W = CTL_W + ADDR_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              oe;
        logic [DATA_W-1:0] dout;
    } ctl_t;

    // synchronised copies of every bus input
    logic [SYNC_W-1:0] raw_in, syn;
    logic [CTL_W-1:0]  ctl_s;
    logic [DATA_W-1:0] ad_s;
    logic [HI_W-1:0]   hi_s;
    logic              e_s, rw_s, ce_s;

    assign raw_in = {hi_addr, ad_in, bus_ce, bus_rw, bus_e, bus_as};

    mbm_sync #(.W(SYNC_W), .STAGES(SYNC_N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (syn)
    );

    assign ctl_s = syn[CTL_W-1:0];
    assign ad_s  = syn[CTL_W +: DATA_W];
    assign hi_s  = syn[CTL_W+DATA_W +: HI_W];
    assign e_s   = ctl_s[CTL_E];
    assign rw_s  = ctl_s[CTL_RW];
    assign ce_s  = ctl_s[CTL_CE];

    // strobe events: bit 0 = address strobe, bit 1 = data strobe
    logic [1:0] stb_rise, stb_fall;
    logic       as_fall, e_rise, e_fall;

    mbm_edge #(.W(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  ({e_s, ctl_s[CTL_AS]}),
        .rise_o (stb_rise),
        .fall_o (stb_fall)
    );

    assign as_fall = stb_fall[0];
    assign e_rise  = stb_rise[1];
    assign e_fall  = stb_fall[1];

    // storage
    ctl_t              ctl_d, ctl_q;
    logic              mem_we;
    logic [DATA_W-1:0] mem_rdata;

    mbm_array #(.AW(STORE_AW), .DW(DATA_W)) u_array (
        .clk     (clk),
        .wr_en   (mem_we),
        .wr_addr (ctl_q.addr[STORE_AW-1:0]),
        .wr_data (ad_s),
        .rd_addr (ctl_q.addr[STORE_AW-1:0]),
        .rd_data (mem_rdata)
    );

    always_comb begin
        ctl_d  = ctl_q;
        mem_we = 1'b0;
        if (as_fall && ce_s) begin
            ctl_d.addr = {hi_s, ad_s};
        end
        if (e_rise && rw_s && ce_s) begin
            ctl_d.dout = mem_rdata;
        end
        ctl_d.oe = e_s && rw_s && ce_s && (ctl_q.oe || e_rise);
        if (e_fall && !rw_s && ce_s) begin
            mem_we = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    logic [ADDR_W-1:0] lat_addr;
    assign lat_addr = ctl_q.addr;
    assign ad_out   = ctl_q.dout;
    assign ad_oe    = ctl_q.oe;
endmodule

// File: rtl/mbm_chk.sv
module mbm_chk #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              as_fall,
    input logic              e_rise,
    input logic              e_s,
    input logic              rw_s,
    input logic              ce_s,
    input logic              ad_oe,
    input logic [DATA_W-1:0] ad_out,
    input logic [ADDR_W-1:0] lat_addr
);
    // R6
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> $past(e_s && rw_s && ce_s));

    // R3
    oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ad_oe) |-> $past(e_rise));

    // R9
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && $past(ad_oe)) |-> $stable(ad_out));

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(as_fall && ce_s) |=> $stable(lat_addr));

    // R5
    ce_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_s |=> !ad_oe);
endmodule

bind mux_bus_mem mbm_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .as_fall  (as_fall),
    .e_rise   (e_rise),
    .e_s      (e_s),
    .rw_s     (rw_s),
    .ce_s     (ce_s),
    .ad_oe    (ad_oe),
    .ad_out   (ad_out),
    .lat_addr (lat_addr)
);

// File: tb/mux_bus_mem_test.sv
module mux_bus_mem_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_as = 1'b0, bus_e = 1'b0, bus_rw = 1'b1, bus_ce = 1'b0;
    logic [6:0] hi_addr = '0;
    logic [7:0] ad_in = '0;
    logic [7:0] ad_out;
    logic       ad_oe;

    int checks = 0;
    int failures = 0;
    logic [7:0] model [2048];

    always #2.5 clk = ~clk;

    mux_bus_mem uut (
        .clk(clk), .rst_n(rst_n), .bus_as(bus_as), .bus_e(bus_e),
        .bus_rw(bus_rw), .bus_ce(bus_ce), .hi_addr(hi_addr),
        .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe)
    );

    // {is_write, address[14:0], data[7:0]}
    localparam logic [23:0] VEC [12] = '{
        {1'b1, 15'h0001, 8'h11},
        {1'b1, 15'h0100, 8'h22},
        {1'b1, 15'h07FF, 8'h33},
        {1'b1, 15'h0123, 8'hA5},
        {1'b1, 15'h0400, 8'hFF},
        {1'b0, 15'h0001, 8'h00},
        {1'b0, 15'h0100, 8'h00},
        {1'b0, 15'h07FF, 8'h00},
        {1'b0, 15'h0123, 8'h00},
        {1'b1, 15'h0100, 8'h44},
        {1'b0, 15'h0100, 8'h00},
        {1'b0, 15'h0400, 8'h00}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic addr_phase(input logic [14:0] a, input logic rw, input logic ce);
        bus_rw  = rw;
        bus_ce  = ce;
        hi_addr = a[14:8];
        ad_in   = a[7:0];
        bus_as  = 1'b1;
        tick(3);
        bus_as  = 1'b0;
        tick(4);
    endtask

    // data phase of a read; the address must already be latched
    task automatic read_phase(input logic [7:0] exp, input logic ce, input string req);
        ad_in = 8'h00;
        bus_e = 1'b1;
        tick(2);
        check(ad_oe == 1'b0, "R3 early", {7'd0, ad_oe}, 8'd0);
        tick(1);
        if (ce) begin
            check(ad_oe == 1'b1, req, {7'd0, ad_oe}, 8'd1);
            check(ad_out == exp, req, ad_out, exp);
        end else begin
            check(ad_oe == 1'b0, req, {7'd0, ad_oe}, 8'd0);
        end
        tick(2);
        bus_e = 1'b0;
        tick(3);
        check(ad_oe == 1'b0, "R6 E low", {7'd0, ad_oe}, 8'd0);
        tick(2);
    endtask

    task automatic write_phase(input logic [7:0] d);
        ad_in = d;
        tick(2);
        bus_e = 1'b1;
        tick(4);
        check(ad_oe == 1'b0, "R4 no drive", {7'd0, ad_oe}, 8'd0);
        bus_e = 1'b0;
        tick(4);
    endtask

    task automatic do_write(input logic [14:0] a, input logic [7:0] d);
        addr_phase(a, 1'b0, 1'b1);
        write_phase(d);
        model[a[10:0]] = d;
        bus_ce = 1'b0;
    endtask

    task automatic do_read(input logic [14:0] a, input string req);
        addr_phase(a, 1'b1, 1'b1);
        read_phase(model[a[10:0]], 1'b1, req);
        bus_ce = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        tick(3);
        check(ad_oe == 1'b0, "R1 oe", {7'd0, ad_oe}, 8'd0);
        check(ad_out == 8'h00, "R1 out", ad_out, 8'h00);
        rst_n = 1'b1;
        tick(3);
        check(ad_oe == 1'b0, "R1 oe after release", {7'd0, ad_oe}, 8'd0);

        // R1: write with no address strobe lands at location 0
        bus_ce = 1'b1;
        bus_rw = 1'b0;
        write_phase(8'h5A);
        model[0] = 8'h5A;
        bus_ce = 1'b0;
        do_read(15'h0000, "R1 reset address");

        // R2 R3 R4: vector table
        for (int i = 0; i < 12; i++) begin
            if (VEC[i][23]) do_write(VEC[i][22:8], VEC[i][7:0]);
            else            do_read(VEC[i][22:8], "R2 R3 R4 table read");
        end

        // R5: disabled write stores nothing
        addr_phase(15'h0123, 1'b0, 1'b0);
        write_phase(8'h0F);
        do_read(15'h0123, "R5 disabled write");

        // R5: disabled read never drives
        addr_phase(15'h0001, 1'b1, 1'b0);
        read_phase(8'h00, 1'b0, "R5 disabled read");

        // R7: repeated data phase without strobe reuses address
        do_read(15'h0100, "R7 first");
        bus_ce = 1'b1;
        bus_rw = 1'b1;
        read_phase(model[11'h100], 1'b1, "R7 reuse");

        // R5 R7: disabled address strobe latches nothing
        addr_phase(15'h0001, 1'b1, 1'b0);
        bus_ce = 1'b1;
        tick(2);
        read_phase(model[11'h100], 1'b1, "R5 disabled strobe keeps address");
        bus_ce = 1'b0;

        // R8: upper address bits alias
        do_write(15'h0805, 8'hC3);
        do_read(15'h0005, "R8 alias");
        do_read(15'h7805, "R8 alias high");

        // R6: CE drop releases the bus
        addr_phase(15'h0123, 1'b1, 1'b1);
        bus_e = 1'b1;
        tick(4);
        check(ad_oe == 1'b1, "R6 before CE drop", {7'd0, ad_oe}, 8'd1);
        // R9: bus changes while driving do not move the output
        ad_in   = 8'hEE;
        hi_addr = 7'h55;
        tick(4);
        check(ad_out == model[11'h123], "R9 hold", ad_out, model[11'h123]);
        bus_ce = 1'b0;
        tick(2);
        check(ad_oe == 1'b1, "R6 CE drop not yet", {7'd0, ad_oe}, 8'd1);
        tick(1);
        check(ad_oe == 1'b0, "R6 CE drop", {7'd0, ad_oe}, 8'd0);
        bus_e = 1'b0;
        tick(4);

        // R6: R/W drop releases the bus
        addr_phase(15'h0400, 1'b1, 1'b1);
        bus_e = 1'b1;
        tick(4);
        check(ad_out == model[11'h400], "R6 read before RW drop", ad_out, model[11'h400]);
        bus_rw = 1'b0;
        tick(3);
        check(ad_oe == 1'b0, "R6 RW drop", {7'd0, ad_oe}, 8'd0);
        bus_rw = 1'b1;
        tick(3);
        bus_e = 1'b0;
        tick(4);
        bus_ce = 1'b0;
        do_read(15'h0400, "R6 location unchanged");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule